// File: doc/BRIEF.md
# Receive Descriptor Destination Dispatcher

This block sits behind the entrance ring of a receive reorder engine. It accepts one 8-word (256-bit) MPDU descriptor per handshake, reads a handful of control fields from it, and produces a compact routing record for the stage that follows. The record names the processing path (normal reorder, reorder bypass or exception), the exit ring the frame leaves on, and three flags: whether the MPDU should be delinked into MSDUs, whether a PN check is wanted, and whether the entry is an exception entry. It also carries a BAR marker.

Exit ring numbers come from the 5-bit destination code in the descriptor. Low codes map straight to rings. Higher codes go through a 32-entry programmable remap table. A separate programmable register holds the ring used for fragments. Both are written through a small register port. A single output register stage with full valid/ready backpressure separates the decision logic from the consumer.

Top module: `rxd_dispatch`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: When the exception flag (word 6 bit 11) is set, the record has path 2 (exception) and `out_exception`=1, and `out_pn_check`=0. This holds whatever the frameless, fragment and PN-valid flags say.
- R3: For an exception entry, an override-valid flag (word 6 bit 13) of 1 makes the ring equal to the override field (word 6 bits [18:14]). An override-valid flag of 0 uses the ring mapped from the destination code.
- R4: For an exception entry, `out_delink` equals the delink flag (word 6 bit 12). A value of 0 means the link-descriptor pointer is passed through; 1 means the MPDU is delinked normally.
- R5: With no exception and no frameless BAR, a set fragment flag (word 2 bit 8) gives path 1 (bypass) and sends the frame to the fragment ring register (config address 32). Both `out_pn_check` and `out_delink` are 0.
- R6: A normal descriptor (none of exception, frameless, fragment) gives path 0, `out_delink`=1, `out_pn_check` equal to the PN-valid flag (word 2 bit 12), and `out_bar` equal to the BAR flag (word 2 bit 11).
- R7: Destination codes (word 5 bits [26:22]) 0 to 6 map to the ring with the same number: software rings 0-4, 5 is the release ring and 6 is the firmware ring. Remap table contents never affect these codes.
- R8: Codes 7 to 31 map to the remap table entry whose config address equals the code. A write is `cfg_wr`=1 with `cfg_addr` 0-31. Table entries and the fragment ring reset to 0. Writes to addresses 33-63 have no effect.
- R9: A frameless-BAR descriptor (word 5 bit 27) without the exception flag gives path 0, `out_bar`=1, ring 0, and delink 0 and PN check 0. Its destination code and its fragment and PN-valid flags are ignored.
- R10: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is 1 and `out_ready` is 0, the record holds stable. Each accepted descriptor yields exactly one record, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Descriptor offered |
| in_ready | output | 1 | Descriptor can be taken |
| in_desc | input | 256 | Descriptor, word w at bits [32w+31:32w] |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | 0-31 remap entry, 32 fragment ring |
| cfg_wdata | input | 5 | Ring number written |
| out_valid | output | 1 | Routing record present |
| out_ready | input | 1 | Consumer takes the record |
| out_ring | output | 5 | Exit ring number |
| out_path | output | 2 | 0 normal, 1 bypass, 2 exception |
| out_delink | output | 1 | Delink into MSDUs |
| out_pn_check | output | 1 | PN check requested |
| out_exception | output | 1 | Exception entry marker |
| out_bar | output | 1 | BAR (framed or frameless) |

## Verification
All 32 destination codes are swept on the normal path twice: once with the table at reset, and once after every entry (including those behind the direct codes) has been written. This separates direct decoding from table lookup and catches a wrong boundary at code 7. The exception path is swept over every code with all four combinations of override-valid and delink. The fragment and frameless flags are also set on alternate codes, which shows that exception priority beats both. Fragment and frameless-BAR descriptors carry conflicting flags to confirm their ordering. A stall sequence checks that the record is held, that input is blocked, and that the next record follows in order.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
    localparam int WORD_W  = 32;
    localparam int N_WORDS = 8;
    localparam int DESC_W  = WORD_W * N_WORDS;
    localparam int CODE_W  = 5;
    localparam int RING_W  = 5;
    localparam int N_ENT   = 1 << CODE_W;

    // bit positions inside the flat descriptor
    localparam int POS_FRAG      = 2 * WORD_W + 8;
    localparam int POS_BAR       = 2 * WORD_W + 11;
    localparam int POS_PNV       = 2 * WORD_W + 12;
    localparam int POS_CODE      = 5 * WORD_W + 22;
    localparam int POS_FRAMELESS = 5 * WORD_W + 27;
    localparam int POS_EXC       = 6 * WORD_W + 11;
    localparam int POS_DELINK    = 6 * WORD_W + 12;
    localparam int POS_OVV       = 6 * WORD_W + 13;
    localparam int POS_OVR       = 6 * WORD_W + 14;

    typedef enum logic [1:0] {
        PATH_NORMAL = 2'd0,
        PATH_BYPASS = 2'd1,
        PATH_EXCEPT = 2'd2
    } path_e;

    typedef struct packed {
        logic              frag;
        logic              bar;
        logic              pn_valid;
        logic              frameless;
        logic              exc;
        logic              delink;
        logic              ovr_valid;
        logic [RING_W-1:0] ovr_ring;
        logic [CODE_W-1:0] code;
    } fields_t;

    typedef struct packed {
        logic [RING_W-1:0] ring;
        path_e             path;
        logic              delink;
        logic              pn_check;
        logic              exception;
        logic              bar;
    } route_t;
endpackage

// File: rtl/rxd_field_extract.sv
module rxd_field_extract
    import rxd_pkg::*;
(
    input  logic [DESC_W-1:0] desc_i,
    output fields_t           fld_o
);
    always_comb begin
        fld_o.frag      = desc_i[POS_FRAG];
        fld_o.bar       = desc_i[POS_BAR];
        fld_o.pn_valid  = desc_i[POS_PNV];
        fld_o.frameless = desc_i[POS_FRAMELESS];
        fld_o.exc       = desc_i[POS_EXC];
        fld_o.delink    = desc_i[POS_DELINK];
        fld_o.ovr_valid = desc_i[POS_OVV];
        fld_o.ovr_ring  = desc_i[POS_OVR +: RING_W];
        fld_o.code      = desc_i[POS_CODE +: CODE_W];
    end

    // the remaining descriptor words are carried by other stages
    logic unused_desc;
    assign unused_desc = ^desc_i;
endmodule

// File: rtl/rxd_ring_remap.sv
module rxd_ring_remap
    import rxd_pkg::*;
#(
    parameter int NUM_DIRECT = 7,
    parameter int CFG_AW     = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [RING_W-1:0] cfg_wdata,
    input  logic [CODE_W-1:0] code_i,
    output logic [RING_W-1:0] mapped_o,
    output logic [RING_W-1:0] frag_ring_o
);
    localparam logic [CFG_AW-1:0] FRAG_ADDR = CFG_AW'(N_ENT);

    typedef struct packed {
        logic [N_ENT-1:0][RING_W-1:0] tbl;
        logic [RING_W-1:0]            frag;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic tbl_wr;

    assign tbl_wr = cfg_wr && (cfg_addr < FRAG_ADDR);

    always_comb begin
        cfg_d = cfg_q;
        if (tbl_wr)
            cfg_d.tbl[cfg_addr[CODE_W-1:0]] = cfg_wdata;
        if (cfg_wr && cfg_addr == FRAG_ADDR)
            cfg_d.frag = cfg_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        if (code_i < CODE_W'(NUM_DIRECT)) mapped_o = RING_W'(code_i);
        else                              mapped_o = cfg_q.tbl[code_i];
    end
    assign frag_ring_o = cfg_q.frag;

    // R8: a table write lands in the addressed entry
    p_tbl_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_wr |=> cfg_q.tbl[$past(cfg_addr[CODE_W-1:0])] == $past(cfg_wdata));

    // R5: a write to the fragment address updates the fragment ring
    p_frag_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_addr == FRAG_ADDR) |=> frag_ring_o == $past(cfg_wdata));
endmodule

// File: rtl/rxd_route_decide.sv
module rxd_route_decide
    import rxd_pkg::*;
(
    input  fields_t           fld_i,
    input  logic [RING_W-1:0] mapped_i,
    input  logic [RING_W-1:0] frag_ring_i,
    output route_t            rt_o
);
    always_comb begin
        rt_o = '0;
        if (fld_i.exc) begin
            rt_o.path      = PATH_EXCEPT;
            rt_o.exception = 1'b1;
            rt_o.delink    = fld_i.delink;
            rt_o.ring      = fld_i.ovr_valid ? fld_i.ovr_ring : mapped_i;
            rt_o.bar       = fld_i.bar;
        end else if (fld_i.frameless) begin
            rt_o.path = PATH_NORMAL;
            rt_o.bar  = 1'b1;
        end else if (fld_i.frag) begin
            rt_o.path = PATH_BYPASS;
            rt_o.ring = frag_ring_i;
            rt_o.bar  = fld_i.bar;
        end else begin
            rt_o.path     = PATH_NORMAL;
            rt_o.ring     = mapped_i;
            rt_o.delink   = 1'b1;
            rt_o.pn_check = fld_i.pn_valid;
            rt_o.bar      = fld_i.bar;
        end
    end
endmodule

// File: rtl/rxd_dispatch.sv
module rxd_dispatch
    import rxd_pkg::*;
#(
    parameter int NUM_DIRECT = 7,
    parameter int CFG_AW     = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [255:0]      in_desc,
    input  logic              cfg_wr,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [4:0]        cfg_wdata,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [4:0]        out_ring,
    output logic [1:0]        out_path,
    output logic              out_delink,
    output logic              out_pn_check,
    output logic              out_exception,
    output logic              out_bar
);
    typedef struct packed {
        logic   valid;
        route_t rec;
    } stage_t;

    fields_t           fld;
    logic [RING_W-1:0] mapped, frag_ring;
    route_t            rt;
    stage_t            st_d, st_q;

    rxd_field_extract u_extract (.desc_i(in_desc), .fld_o(fld));

    rxd_ring_remap #(.NUM_DIRECT(NUM_DIRECT), .CFG_AW(CFG_AW)) u_remap (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .code_i(fld.code), .mapped_o(mapped),
        .frag_ring_o(frag_ring)
    );

    rxd_route_decide u_decide (
        .fld_i(fld), .mapped_i(mapped), .frag_ring_i(frag_ring), .rt_o(rt)
    );

    assign in_ready = !st_q.valid || out_ready;

    always_comb begin
        st_d = st_q;
        if (out_ready) st_d.valid = 1'b0;
        if (in_valid && in_ready) begin
            st_d.valid = 1'b1;
            st_d.rec   = rt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid     = st_q.valid;
    assign out_ring      = st_q.rec.ring;
    assign out_path      = st_q.rec.path;
    assign out_delink    = st_q.rec.delink;
    assign out_pn_check  = st_q.rec.pn_check;
    assign out_exception = st_q.rec.exception;
    assign out_bar       = st_q.rec.bar;

    // R10: a stalled record is held unchanged
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> out_valid && $stable(st_q.rec));

    // R10: an accepted descriptor always produces a record next cycle
    p_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    // R2: the exception marker and the exception path agree
    p_exc_mark_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_exception == (out_path == PATH_EXCEPT)));

    // R5: bypass records never ask for PN check or delinking
    p_bypass_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_path == PATH_BYPASS) |-> !out_pn_check && !out_delink);

    // R2: exception records never request a PN check
    p_exc_nopn_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_exception) |-> !out_pn_check);
endmodule

// File: tb/rxd_dispatch_test.sv
`timescale 1ns/1ps
module rxd_dispatch_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [255:0] in_desc = '0;
    logic         cfg_wr = 1'b0;
    logic [5:0]   cfg_addr = '0;
    logic [4:0]   cfg_wdata = '0;
    logic         out_valid;
    logic         out_ready = 1'b1;
    logic [4:0]   out_ring;
    logic [1:0]   out_path;
    logic         out_delink, out_pn_check, out_exception, out_bar;

    int total = 0;
    int fails = 0;
    bit done = 0;
    logic [4:0] btab [32];
    logic [4:0] bfrag = '0;

    always #2.5 clk = ~clk;

    rxd_dispatch uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_desc(in_desc), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .out_valid(out_valid), .out_ready(out_ready),
        .out_ring(out_ring), .out_path(out_path), .out_delink(out_delink),
        .out_pn_check(out_pn_check), .out_exception(out_exception),
        .out_bar(out_bar)
    );

    function automatic logic [255:0] mk(input logic [4:0] code, input bit frag,
        input bit pnv, input bit bar, input bit fless, input bit exc,
        input bit del, input bit ovv, input logic [4:0] ovr, input int seed);
        logic [255:0] d;
        d = '0;
        d[31:0]    = 32'hA5C3_0000 ^ seed;
        d[63:32]   = 32'h1234_5678 + seed;
        d[255:224] = 32'hDEAD_0000 | seed;
        d[2*32+8]  = frag;
        d[2*32+11] = bar;
        d[2*32+12] = pnv;
        d[5*32+22 +: 5] = code;
        d[5*32+27] = fless;
        d[6*32+11] = exc;
        d[6*32+12] = del;
        d[6*32+13] = ovv;
        d[6*32+14 +: 5] = ovr;
        return d;
    endfunction

    // {valid, ring, path, delink, pn, exc, bar}
    function automatic logic [11:0] model(input logic [255:0] d);
        logic [4:0] code, mapped;
        code   = d[5*32+22 +: 5];
        mapped = (code < 5'd7) ? code : btab[code];
        if (d[6*32+11])
            return {1'b1, (d[6*32+13] ? d[6*32+14 +: 5] : mapped), 2'd2,
                    d[6*32+12], 1'b0, 1'b1, d[2*32+11]};
        if (d[5*32+27])
            return {1'b1, 5'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1};
        if (d[2*32+8])
            return {1'b1, bfrag, 2'd1, 1'b0, 1'b0, 1'b0, d[2*32+11]};
        return {1'b1, mapped, 2'd0, 1'b1, d[2*32+12], 1'b0, d[2*32+11]};
    endfunction

    function automatic logic [11:0] actual();
        return {out_valid, out_ring, out_path, out_delink, out_pn_check,
                out_exception, out_bar};
    endfunction

    task automatic check(input string req, input logic [11:0] act,
                         input logic [11:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg(input logic [5:0] a, input logic [4:0] v);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = v;
        @(negedge clk);
        cfg_wr = 1'b0;
        if (a < 6'd32) btab[a[4:0]] = v;
        else if (a == 6'd32) bfrag = v;
    endtask

    task automatic send(input string req, input logic [255:0] d);
        @(negedge clk);
        in_desc = d; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(req, actual(), model(d));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; total++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) btab[i] = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 out_valid", {11'd0, out_valid}, 12'd0);
        check("R1 in_ready", {11'd0, in_ready}, 12'd1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 in_ready after release", {11'd0, in_ready}, 12'd1);

        // R6 R7 R8: normal sweep with table at reset (entries read 0)
        for (int c = 0; c < 32; c++)
            send("R6/R7/R8 normal reset table",
                 mk(5'(c), 0, c[0], c[1], 0, 0, 0, 0, 5'(31 - c), c));

        // program table, including entries behind direct codes (R7)
        for (int c = 0; c < 32; c++) cfg(6'(c), (c < 7) ? 5'd31 : 5'((c * 7 + 3) % 32));
        cfg(6'd32, 5'd19);
        cfg(6'd40, 5'd5);   // R8: out-of-range address, no effect

        for (int c = 0; c < 32; c++)
            send("R6/R7/R8 normal programmed",
                 mk(5'(c), 0, ~c[0], c[2], 0, 0, 0, 0, 5'(c), c + 100));

        // R2 R3 R4: exception sweep with conflicting flags on odd codes
        for (int c = 0; c < 32; c++)
            for (int m = 0; m < 4; m++)
                send("R2/R3/R4 exception",
                     mk(5'(c), c[0], 1, m[0], c[0], 1, m[1], m[0], 5'(31 - c), c * 4 + m));

        // R5: fragments go to the fragment register (19), PN flag ignored
        for (int c = 0; c < 32; c += 5)
            send("R5 fragment", mk(5'(c), 1, 1, c[0], 0, 0, 1, 1, 5'd3, c));

        // R9: frameless BAR beats fragment, code and PN flags
        send("R9 frameless", mk(5'd9, 1, 1, 0, 1, 0, 0, 0, 5'd0, 7));
        send("R9 frameless", mk(5'd2, 0, 1, 0, 1, 0, 1, 1, 5'd12, 8));

        // R10: backpressure
        @(negedge clk);
        out_ready = 1'b0;
        in_desc = mk(5'd3, 0, 1, 0, 0, 0, 0, 0, 5'd0, 1); in_valid = 1'b1;
        @(negedge clk);
        check("R10 first record", actual(), model(in_desc));
        check("R10 in_ready low while stalled", {11'd0, in_ready}, 12'd0);
        in_desc = mk(5'd20, 0, 0, 1, 0, 0, 0, 0, 5'd0, 2);
        repeat (3) @(negedge clk);
        check("R10 record held", actual(), model(mk(5'd3, 0, 1, 0, 0, 0, 0, 0, 5'd0, 1)));
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R10 second record in order", actual(), model(in_desc));
        @(negedge clk);
        check("R10 no duplicate", {11'd0, out_valid}, 12'd0);

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule